// File: doc/BRIEF.md
# Half-Flash Converter Host Sequencer

This block sits on the host side of an external 8-bit half-flash analog-to-digital converter and drives its parallel control pins. A single request on the user side (`req_valid` while `req_ready` is high) starts one conversion. When the conversion finishes, the controller returns the result byte together with the converter's overflow status in a one-cycle `rsp_valid` pulse.

Three pin sequences are available and are chosen per request by `req_seq`:

- **Read-only.** The read strobe both starts the conversion and waits on the converter's open-drain ready line.
- **Write-then-read, interrupt wait.** The controller waits for the converter's interrupt before it reads.
- **Write-then-read, fixed delay.** A faster variant that ignores the interrupt and reads after a fixed delay.

Every pin timing is a cycle count. It is derived from a clock-period parameter and a nanosecond parameter, rounded up so that each minimum is met. The ready and interrupt inputs are asynchronous and pass through a parameterised synchroniser. A timeout abandons any conversion whose completion signal never arrives and reports an error.

Top module: `hfadc_host_ctrl`

## Requirements
- R1: After reset, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high, `adc_mode` is low, `rsp_valid` is low and `req_ready` is high.
- R2: `req_seq` is decoded as follows: 2'b00 selects read-only, 2'b01 selects write-then-read with interrupt wait, and 2'b10 or 2'b11 selects write-then-read with a fixed delay. `adc_mode` is driven low for read-only and high for both write-then-read sequences. It changes only while `adc_cs_n` is high, and `adc_wr_n` stays high whenever `adc_mode` is low.
- R3: In read-only, `adc_cs_n` and `adc_rd_n` fall in the same cycle. The conversion completes once the synchronised `adc_rdy` has been seen low and then high; `rsp_valid` follows the rise of `adc_rdy` within SYNC_STAGES+2 cycles.
- R4: In both write-then-read sequences, `adc_wr_n` is held low, with `adc_cs_n` low, for exactly ceil(T_WR_NS/CLK_NS) cycles.
- R5: With interrupt wait, `adc_rd_n` falls 1 to SYNC_STAGES+2 cycles after `adc_int_n` falls, and never before it.
- R6: With the fixed delay, `adc_rd_n` falls exactly ceil(T_FAST_NS/CLK_NS) cycles after `adc_wr_n` rises, whatever `adc_int_n` does.
- R7: In both write-then-read sequences, `adc_rd_n` stays low for ceil(T_ACC_NS/CLK_NS) cycles. In every sequence, `adc_db` is captured into `rsp_data` and `rsp_ovf` is set to the inverse of `adc_ofl_n` (1 means over-range). `rsp_valid` is a single-cycle pulse with `rsp_err` low, in the cycle where `adc_rd_n` and `adc_cs_n` return high.
- R8: `adc_cs_n` stays high for at least ceil(T_GAP_NS/CLK_NS) cycles between the end of one conversion and the start of the next.
- R9: A conversion waiting on ready or interrupt for ceil(T_TO_NS/CLK_NS) cycles, counted from the start of the wait, is abandoned. The read strobe is not issued in interrupt wait. `rsp_valid` pulses with `rsp_err` high and `rsp_data` zero, and the controller then serves the next request normally.
- R10: `adc_rd_n` or `adc_wr_n` is low only while `adc_cs_n` is low, and the two are never low together.
- R11: A request is taken only while `req_ready` is high. `req_ready` is low from acceptance until the recovery gap ends, and a request raised in that time starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request |
| req_seq | input | 2 | Sequence select (see R2) |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | DW | Conversion result |
| rsp_ovf | output | 1 | Input was over range |
| rsp_err | output | 1 | Conversion timed out |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_wr_n | output | 1 | Conversion start strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_mode | output | 1 | Sequence mode pin, high for write-then-read |
| adc_rdy | input | 1 | Open-drain ready line (pulled up), asynchronous |
| adc_int_n | input | 1 | Conversion-done interrupt, active low, asynchronous |
| adc_db | input | DW | Converter data bus |
| adc_ofl_n | input | 1 | Overflow flag, active low |

## Verification
A sequencer stuck in the wrong state shows at the pins within one cycle. A strobe can appear without select, read and write can be low together, or `adc_mode` can move during a conversion. A miscounted delay shows as a strobe edge one or more cycles off the expected count, visible when that strobe next changes. A lost ready or interrupt condition shows as a timeout response exactly ceil(T_TO_NS/CLK_NS) cycles into the wait, instead of data. Corrupted capture shows only in the `rsp_valid` cycle, so the bench compares the returned data, overflow and error bits on every response.

// File: rtl/hfadc_pkg.sv
`timescale 1ns/1ps
package hfadc_pkg;

   localparam logic [1:0] SEQ_RDONLY  = 2'b00;
   localparam logic [1:0] SEQ_INTWAIT = 2'b01;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RDM   = 3'd1,
      ST_WRL   = 3'd2,
      ST_WINT  = 3'd3,
      ST_WFAST = 3'd4,
      ST_RACC  = 3'd5,
      ST_GAP   = 3'd6
   } hf_state_e;

   // nanoseconds to whole cycles, rounded up
   function automatic int ns2cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hfadc_sync.sv
`timescale 1ns/1ps
module hfadc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= {STAGES{RST_VAL}};
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hfadc_seq.sv
`timescale 1ns/1ps
module hfadc_seq
   import hfadc_pkg::*;
#(
   parameter int WR_CYC   = 30,
   parameter int FAST_CYC = 30,
   parameter int ACC_CYC  = 13,
   parameter int GAP_CYC  = 25,
   parameter int TO_CYC   = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_seq,
   input  logic       rdy_s,
   input  logic       int_s,
   output logic       req_ready,
   output logic       cap_stb,
   output logic       tmo_stb,
   output logic       cs_n,
   output logic       wr_n,
   output logic       rd_n,
   output logic       mode
);
   localparam int MAXC = max2(max2(WR_CYC, FAST_CYC), max2(max2(ACC_CYC, GAP_CYC), TO_CYC));
   localparam int CW   = $clog2(MAXC + 1);

   localparam logic [CW-1:0] WR_END   = CW'(WR_CYC - 1);
   localparam logic [CW-1:0] FAST_END = CW'(FAST_CYC - 1);
   localparam logic [CW-1:0] ACC_END  = CW'(ACC_CYC - 1);
   localparam logic [CW-1:0] GAP_END  = CW'(GAP_CYC - 1);
   localparam logic [CW-1:0] TO_END   = CW'(TO_CYC - 1);

   hf_state_e      st, st_n;
   logic [CW-1:0]  cnt;
   logic           armed;
   logic           fast_q;

   always_comb begin
      st_n    = st;
      cap_stb = 1'b0;
      tmo_stb = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (req_valid) st_n = (req_seq == SEQ_RDONLY) ? ST_RDM : ST_WRL;
         end
         ST_RDM: begin
            if (armed && rdy_s) begin
               st_n    = ST_GAP;
               cap_stb = 1'b1;
            end else if (cnt == TO_END) begin
               st_n    = ST_GAP;
               tmo_stb = 1'b1;
            end
         end
         ST_WRL: begin
            if (cnt == WR_END) st_n = fast_q ? ST_WFAST : ST_WINT;
         end
         ST_WINT: begin
            if (!int_s) begin
               st_n = ST_RACC;
            end else if (cnt == TO_END) begin
               st_n    = ST_GAP;
               tmo_stb = 1'b1;
            end
         end
         ST_WFAST: begin
            if (cnt == FAST_END) st_n = ST_RACC;
         end
         ST_RACC: begin
            if (cnt == ACC_END) begin
               st_n    = ST_GAP;
               cap_stb = 1'b1;
            end
         end
         ST_GAP: begin
            if (cnt == GAP_END) st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         armed  <= 1'b0;
         fast_q <= 1'b0;
         mode   <= 1'b0;
         cs_n   <= 1'b1;
         wr_n   <= 1'b1;
         rd_n   <= 1'b1;
      end else begin
         st    <= st_n;
         cnt   <= (st_n != st) ? '0 : cnt + 1'b1;
         armed <= (st_n == ST_RDM) && (armed || ((st == ST_RDM) && !rdy_s));
         if (st == ST_IDLE && req_valid) begin
            mode   <= (req_seq != SEQ_RDONLY);
            fast_q <= req_seq[1];
         end
         // pins registered from the next state so they change cleanly
         cs_n <= !(st_n inside {ST_RDM, ST_WRL, ST_WINT, ST_WFAST, ST_RACC});
         wr_n <= (st_n != ST_WRL);
         rd_n <= !(st_n inside {ST_RDM, ST_RACC});
      end
   end

   assign req_ready = (st == ST_IDLE);

endmodule

// File: rtl/hfadc_capture.sv
`timescale 1ns/1ps
module hfadc_capture #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_stb,
   input  logic          tmo_stb,
   input  logic [DW-1:0] db,
   input  logic          ofl_n,
   output logic          vld,
   output logic [DW-1:0] data,
   output logic          ovf,
   output logic          err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         data <= '0;
         ovf  <= 1'b0;
         err  <= 1'b0;
      end else begin
         vld <= cap_stb | tmo_stb;
         if (cap_stb) begin
            data <= db;
            ovf  <= !ofl_n;
            err  <= 1'b0;
         end else if (tmo_stb) begin
            data <= '0;
            ovf  <= 1'b0;
            err  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hfadc_host_ctrl.sv
`timescale 1ns/1ps
module hfadc_host_ctrl
   import hfadc_pkg::*;
#(
   parameter int DW          = 8,
   parameter int CLK_NS      = 20,
   parameter int T_WR_NS     = 600,
   parameter int T_FAST_NS   = 600,
   parameter int T_ACC_NS    = 250,
   parameter int T_GAP_NS    = 500,
   parameter int T_TO_NS     = 4000,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_seq,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          rsp_ovf,
   output logic          rsp_err,
   output logic          adc_cs_n,
   output logic          adc_wr_n,
   output logic          adc_rd_n,
   output logic          adc_mode,
   input  logic          adc_rdy,
   input  logic          adc_int_n,
   input  logic [DW-1:0] adc_db,
   input  logic          adc_ofl_n
);
   localparam int WR_CYC   = ns2cyc(T_WR_NS, CLK_NS);
   localparam int FAST_CYC = ns2cyc(T_FAST_NS, CLK_NS);
   localparam int ACC_CYC  = ns2cyc(T_ACC_NS, CLK_NS);
   localparam int GAP_CYC  = ns2cyc(T_GAP_NS, CLK_NS);
   localparam int TO_CYC   = ns2cyc(T_TO_NS, CLK_NS);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("hfadc_host_ctrl: DW must be at least 1");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("hfadc_host_ctrl: CLK_NS must be positive");
      end
      if (WR_CYC < 1 || FAST_CYC < 1 || ACC_CYC < 1) begin : g_bad_pulse
         $error("hfadc_host_ctrl: strobe timings must be at least one cycle");
      end
      if (GAP_CYC <= SYNC_STAGES + 1) begin : g_bad_gap
         $error("hfadc_host_ctrl: recovery gap must outlast the synchroniser");
      end
      if (TO_CYC <= SYNC_STAGES + 2) begin : g_bad_to
         $error("hfadc_host_ctrl: timeout too short for synchroniser latency");
      end
   endgenerate

   logic rdy_s, int_s, cap_stb, tmo_stb;

   hfadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rdy (
      .clk(clk), .rst_n(rst_n), .d(adc_rdy), .q(rdy_s));

   hfadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_int (
      .clk(clk), .rst_n(rst_n), .d(adc_int_n), .q(int_s));

   hfadc_seq #(
      .WR_CYC(WR_CYC), .FAST_CYC(FAST_CYC), .ACC_CYC(ACC_CYC),
      .GAP_CYC(GAP_CYC), .TO_CYC(TO_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_seq(req_seq),
      .rdy_s(rdy_s), .int_s(int_s),
      .req_ready(req_ready), .cap_stb(cap_stb), .tmo_stb(tmo_stb),
      .cs_n(adc_cs_n), .wr_n(adc_wr_n), .rd_n(adc_rd_n), .mode(adc_mode));

   hfadc_capture #(.DW(DW)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .cap_stb(cap_stb), .tmo_stb(tmo_stb),
      .db(adc_db), .ofl_n(adc_ofl_n),
      .vld(rsp_valid), .data(rsp_data), .ovf(rsp_ovf), .err(rsp_err));

endmodule

// File: rtl/hfadc_host_chk.sv
`timescale 1ns/1ps
module hfadc_host_chk
   import hfadc_pkg::*;
#(
   parameter int CLK_NS   = 20,
   parameter int T_WR_NS  = 600,
   parameter int T_GAP_NS = 500
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic adc_cs_n,
   input logic adc_wr_n,
   input logic adc_rd_n,
   input logic adc_mode
);
   localparam int WR_CYC  = ns2cyc(T_WR_NS, CLK_NS);
   localparam int GAP_CYC = ns2cyc(T_GAP_NS, CLK_NS);
   localparam int SAT     = 1 << 20;

   int wr_lo_cnt;
   int cs_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_lo_cnt <= 0;
         cs_hi_cnt <= SAT;
      end else begin
         wr_lo_cnt <= adc_wr_n ? 0 : wr_lo_cnt + 1;
         cs_hi_cnt <= !adc_cs_n ? 0 : ((cs_hi_cnt < SAT) ? cs_hi_cnt + 1 : SAT);
      end
   end

   // R10
   rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n |-> !adc_cs_n);
   // R10
   wr_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_wr_n |-> !adc_cs_n);
   // R10
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!adc_rd_n && !adc_wr_n));
   // R2
   wr_quiet_rdonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_mode |-> adc_wr_n);
   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_cs_n && !$past(adc_cs_n)) |-> $stable(adc_mode));
   // R3
   rdonly_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(adc_cs_n) && !adc_mode) |-> !adc_rd_n);
   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R11
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (adc_cs_n && adc_wr_n && adc_rd_n));
   // R4
   wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_wr_n) |-> (wr_lo_cnt == WR_CYC));
   // R8
   recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_cs_n) |-> (cs_hi_cnt >= GAP_CYC));

endmodule

bind hfadc_host_ctrl hfadc_host_chk #(
   .CLK_NS(CLK_NS), .T_WR_NS(T_WR_NS), .T_GAP_NS(T_GAP_NS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
   .adc_mode(adc_mode));

// File: tb/sim_hfadc_host_ctrl.sv
`timescale 1ns/1ps
module sim_hfadc_host_ctrl;
   localparam int CLK_PERIOD = 20;
   localparam int DW     = 8;
   localparam int T_WR   = 600;
   localparam int T_FAST = 600;
   localparam int T_ACC  = 250;
   localparam int T_GAP  = 500;
   localparam int T_TO   = 4000;
   localparam int SYNC   = 2;
   localparam int WR_CYC   = (T_WR   + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int FAST_CYC = (T_FAST + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int ACC_CYC  = (T_ACC  + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int GAP_CYC  = (T_GAP  + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int TO_CYC   = (T_TO   + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_seq = 2'b00;
   logic req_ready, rsp_valid, rsp_ovf, rsp_err;
   logic [DW-1:0] rsp_data;
   logic adc_cs_n, adc_wr_n, adc_rd_n, adc_mode;
   logic adc_rdy = 1'b1;
   logic adc_int_n = 1'b1;
   logic [DW-1:0] adc_db;
   logic adc_ofl_n;

   int  conv_val = 0;
   bit  conv_ofl = 1'b0;
   int  rd_busy = 0;
   int  int_dly = -1;

   assign adc_db    = conv_val[DW-1:0];
   assign adc_ofl_n = !conv_ofl;

   hfadc_host_ctrl #(
      .DW(DW), .CLK_NS(CLK_PERIOD), .T_WR_NS(T_WR), .T_FAST_NS(T_FAST),
      .T_ACC_NS(T_ACC), .T_GAP_NS(T_GAP), .T_TO_NS(T_TO), .SYNC_STAGES(SYNC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_ovf(rsp_ovf), .rsp_err(rsp_err), .adc_cs_n(adc_cs_n),
      .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_mode(adc_mode),
      .adc_rdy(adc_rdy), .adc_int_n(adc_int_n), .adc_db(adc_db),
      .adc_ofl_n(adc_ofl_n));

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // event log filled at the falling clock edge
   bit p_cs = 1'b1, p_wr = 1'b1, p_rd = 1'b1, p_rsp = 1'b0;
   int cs_fall_c = 0, cs_rise_c = -100000, wr_fall_c = 0, wr_rise_c = 0;
   int rd_fall_c = 0, int_fall_c = 0, rdy_rise_c = 0, rsp_c = 0;
   int rsp_count = 0, wr_falls = 0, rd_falls = 0, cs_falls = 0;
   int min_gap = 1000000, proto_bad = 0, pulse_bad = 0;
   bit mode_at_start = 1'b0;
   int got_data = 0;
   bit got_ovf = 1'b0, got_err = 1'b0;
   int rd_cnt = 0, int_cd = -1;

   always @(negedge clk) begin
      if (rst_n) begin
         // observe the controller
         if (p_cs && !adc_cs_n) begin
            cs_fall_c = cyc; cs_falls++; mode_at_start = adc_mode;
            if (cyc - cs_rise_c < min_gap) min_gap = cyc - cs_rise_c;
         end
         if (!p_cs && adc_cs_n) cs_rise_c = cyc;
         if (p_wr && !adc_wr_n) begin wr_fall_c = cyc; wr_falls++; end
         if (!p_wr && adc_wr_n) wr_rise_c = cyc;
         if (p_rd && !adc_rd_n) begin rd_fall_c = cyc; rd_falls++; end
         if (rsp_valid) begin
            rsp_c = cyc; rsp_count++;
            got_data = int'(rsp_data); got_ovf = rsp_ovf; got_err = rsp_err;
            if (p_rsp) pulse_bad++;
         end
         if (((!adc_rd_n || !adc_wr_n) && adc_cs_n) || (!adc_rd_n && !adc_wr_n))
            proto_bad++;

         // converter model: open-drain ready in read-only mode
         if (!adc_mode && !adc_cs_n) begin
            rd_cnt++;
            if (rd_cnt >= 2 && (rd_busy < 0 || rd_cnt < 2 + rd_busy)) adc_rdy = 1'b0;
            else begin
               if (!adc_rdy) rdy_rise_c = cyc;
               adc_rdy = 1'b1;
            end
         end else begin
            rd_cnt = 0;
            adc_rdy = 1'b1;
         end
         // converter model: interrupt
         if ((!p_rd && adc_rd_n) || (!p_cs && adc_cs_n)) begin
            adc_int_n = 1'b1; int_cd = -1;
         end else begin
            if (!p_wr && adc_wr_n && int_dly >= 1) int_cd = int_dly;
            if (p_rd && !adc_rd_n && adc_mode) adc_int_n = 1'b0;
            if (int_cd == 0) begin
               adc_int_n = 1'b0; int_fall_c = cyc; int_cd = -1;
            end else if (int_cd > 0) int_cd--;
         end
         p_cs = adc_cs_n; p_wr = adc_wr_n; p_rd = adc_rd_n; p_rsp = rsp_valid;
      end
   end

   task automatic do_conv(input logic [1:0] seq, input int val, input bit ofl,
                          input int busy, input int idly, input bit poke);
      int start_cnt;
      int guard;
      conv_val = val; conv_ofl = ofl; rd_busy = busy; int_dly = idly;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      start_cnt = rsp_count;
      req_valid = 1'b1; req_seq = seq;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         chk(req_ready == 1'b0, "R11 ready low while busy", int'(req_ready), 0);
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      guard = 0;
      while (rsp_count == start_cnt && guard < 5000) begin
         @(posedge clk); guard++;
      end
      chk(guard < 5000, "R7 response arrives", guard, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_LIMIT, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int w0, r0, c0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes idle high",
          int'({adc_cs_n, adc_wr_n, adc_rd_n}), 7);
      chk(adc_mode == 1'b0, "R1 mode low", int'(adc_mode), 0);
      chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
      chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

      // read-only sequence
      w0 = wr_falls;
      do_conv(2'b00, 8'hA5, 1'b0, 20, -1, 1'b0);
      chk(mode_at_start == 1'b0, "R2 mode low in read-only", int'(mode_at_start), 0);
      chk(rd_fall_c == cs_fall_c, "R3 read with select", rd_fall_c, cs_fall_c);
      chk(wr_falls == w0, "R3 no write strobe", wr_falls, w0);
      chk(rsp_c - rdy_rise_c >= 1 && rsp_c - rdy_rise_c <= SYNC + 2,
          "R3 ready to response", rsp_c - rdy_rise_c, SYNC + 1);
      chk(got_data == 8'hA5, "R7 read-only data", got_data, 8'hA5);
      chk(got_ovf == 1'b0 && got_err == 1'b0, "R7 read-only flags",
          int'({got_ovf, got_err}), 0);

      // write-then-read, interrupt wait
      do_conv(2'b01, 8'h3C, 1'b1, 0, 50, 1'b0);
      chk(mode_at_start == 1'b1, "R2 mode high", int'(mode_at_start), 1);
      chk(wr_rise_c - wr_fall_c == WR_CYC, "R4 write width", wr_rise_c - wr_fall_c, WR_CYC);
      chk(rd_fall_c - int_fall_c >= 1 && rd_fall_c - int_fall_c <= SYNC + 2,
          "R5 read after interrupt", rd_fall_c - int_fall_c, SYNC + 1);
      chk(rsp_c - rd_fall_c == ACC_CYC, "R7 read width", rsp_c - rd_fall_c, ACC_CYC);
      chk(got_data == 8'h3C && got_ovf == 1'b1 && got_err == 1'b0, "R7 int-wait data",
          got_data, 8'h3C);

      // fixed delay, interrupt never arrives before read
      do_conv(2'b10, 8'h81, 1'b0, 0, -1, 1'b0);
      chk(wr_rise_c - wr_fall_c == WR_CYC, "R4 fast write width", wr_rise_c - wr_fall_c, WR_CYC);
      chk(rd_fall_c - wr_rise_c == FAST_CYC, "R6 fixed delay", rd_fall_c - wr_rise_c, FAST_CYC);
      chk(got_data == 8'h81 && got_err == 1'b0, "R7 fast data", got_data, 8'h81);

      // code 3 also fast; early interrupt ignored
      do_conv(2'b11, 8'hFF, 1'b1, 0, 3, 1'b0);
      chk(mode_at_start == 1'b1, "R2 code 3 mode high", int'(mode_at_start), 1);
      chk(rd_fall_c - wr_rise_c == FAST_CYC, "R6 interrupt ignored", rd_fall_c - wr_rise_c, FAST_CYC);
      chk(got_data == 8'hFF && got_ovf == 1'b1, "R7 full-scale overflow", got_data, 8'hFF);

      // interrupt-wait timeout
      r0 = rd_falls;
      do_conv(2'b01, 8'h55, 1'b0, 0, -1, 1'b0);
      chk(rd_falls == r0, "R9 no read on timeout", rd_falls, r0);
      chk(got_err == 1'b1 && got_data == 0, "R9 error response", int'(got_err), 1);
      chk(rsp_c - wr_rise_c == TO_CYC, "R9 int-wait timeout length", rsp_c - wr_rise_c, TO_CYC);

      // read-only timeout
      do_conv(2'b00, 8'h11, 1'b0, -1, -1, 1'b0);
      chk(got_err == 1'b1 && got_data == 0, "R9 read-only error", int'(got_err), 1);
      chk(rsp_c - rd_fall_c == TO_CYC, "R9 read-only timeout length", rsp_c - rd_fall_c, TO_CYC);

      // normal conversion after timeout, with a request raised while busy
      c0 = cs_falls;
      do_conv(2'b01, 8'hC3, 1'b0, 0, 50, 1'b1);
      chk(got_data == 8'hC3 && got_err == 1'b0, "R9 recovery after timeout", got_data, 8'hC3);
      repeat (GAP_CYC + 5) @(negedge clk);
      chk(cs_falls - c0 == 1, "R11 busy request ignored", cs_falls - c0, 1);
      chk(req_ready == 1'b1, "R11 idle again", int'(req_ready), 1);

      // short read-only conversion back to back
      do_conv(2'b00, 8'h7E, 1'b1, 5, -1, 1'b0);
      chk(got_data == 8'h7E && got_ovf == 1'b1, "R3 short busy data", got_data, 8'h7E);

      chk(min_gap >= GAP_CYC, "R8 recovery gap", min_gap, GAP_CYC);
      chk(proto_bad == 0, "R10 strobe rules", proto_bad, 0);
      chk(pulse_bad == 0, "R7 single-cycle valid", pulse_bad, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule